// File: doc/BRIEF.md
# I2C Engine Ownership Arbiter

This block decides who may drive a shared I2C engine: a software requester or a hardware requester that runs on its own. It keeps a two-bit ownership status (idle, software, hardware), grants requests, accepts explicit releases from software, and returns the status to idle when told to. The priority setting decides whether hardware may take the engine away from software between transfers, or must wait until software lets go.

Software transfer starts (go pulses) are handled here too. A go pulse fires a start strobe toward the engine only when software owns the engine and no transfer is running. A go pulse that arrives while hardware owns the engine is either held until the engine is free or rejected, depending on a configuration bit. When hardware takes the engine from software, software gets the engine back once hardware is done, and a restart strobe is raised. A full engine reset strobe is produced only when a reset is requested while software owns the engine.

All outputs come from registers and change one clock after the input that causes them.

Top module: `i2c_own_arb`

## Requirements
- R1: `owner` reads 0 for idle, 1 for software and 2 for hardware, and never 3. It is 0 during and after reset. `sw_grant` is high exactly when `owner` is 1, and `hw_grant` is high exactly when `owner` is 2.
- R2: When the engine is idle and `sw_req` is high without `hw_req`, `owner` becomes 1 at the next clock edge.
- R3: A `sw_done` pulse while software owns the engine makes `owner` 0 at the next edge. A `sw_done` pulse while hardware owns the engine cancels any held go and any pending restart.
- R4: A `status_clr` pulse returns `owner` to 0 from any state, and drops held go and restart state.
- R5: A `soft_rst` pulse clears the status as `status_clr` does. It also raises `engine_reset` for one cycle, but only if `owner` was 1 in that cycle.
- R6: A `sw_go` pulse while software owns the engine with no transfer running raises `go_fire` for one cycle and marks a transfer as running. A `sw_go` pulse while a transfer is running, or while the engine is idle, raises `go_reject` instead. An `xact_end` pulse ends the running transfer.
- R7: With `prio_high` = 0, a `hw_req` takes the engine from software (`owner` becomes 2) when no transfer is running, or in the cycle `xact_end` is pulsed. It never does so in the middle of a running transfer.
- R8: With `prio_high` = 1, `hw_req` never takes the engine from software. Hardware gets the engine only after software releases it.
- R9: From idle, when software and hardware request in the same cycle, hardware wins if `prio_high` = 0 and software wins if `prio_high` = 1.
- R10: A `sw_go` pulse while hardware owns the engine is held when `no_queue_go` = 0, and raises `go_reject` when `no_queue_go` = 1.
- R11: A held go is granted in the cycle after hardware returns the engine to idle. `owner` becomes 1 and `go_fire` pulses at the same edge.
- R12: If hardware took the engine from software, software regains it (`owner` = 1) in the cycle after hardware returns to idle, with a one-cycle `restart` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_req | input | 1 | Software asks for the engine |
| sw_done | input | 1 | Software release pulse |
| status_clr | input | 1 | Ownership status clear pulse |
| soft_rst | input | 1 | Full engine reset request pulse |
| sw_go | input | 1 | Software transfer start pulse |
| xact_end | input | 1 | Current software transfer finished |
| hw_req | input | 1 | Hardware requester wants the engine (level) |
| prio_high | input | 1 | 1: software is not preempted; 0: hardware preempts at transfer boundaries |
| no_queue_go | input | 1 | 1: reject go pulses while hardware owns the engine |
| owner | output | 2 | Ownership status: 0 idle, 1 software, 2 hardware |
| sw_grant | output | 1 | Software owns the engine |
| hw_grant | output | 1 | Hardware owns the engine |
| go_fire | output | 1 | One-cycle start strobe to the engine |
| go_reject | output | 1 | One-cycle strobe: a go pulse was refused |
| engine_reset | output | 1 | One-cycle full engine reset strobe |
| restart | output | 1 | One-cycle strobe: software regained the engine after preemption |

## Verification
A wrong ownership state shows on `owner` and the grant pins at the very next edge, so each cycle of the vector table compares them. The hidden flags are a running transfer, a held go and a pending restart. If one of them is wrong, it shows later as a `go_fire`, `go_reject` or `restart` pulse that is missing or extra, or as a preemption that comes too early or too late. The bench therefore continues each scenario through the hardware release and the resume cycle. If the tie rule is reversed, or preemption ignores the transfer boundary, `owner` takes the wrong value one cycle after the contended request.

// File: rtl/i2c_own_pkg.sv
package i2c_own_pkg;

  localparam int OWN_W = 2;

  typedef enum logic [OWN_W-1:0] {
    OWN_IDLE = 2'd0,
    OWN_SW   = 2'd1,
    OWN_HW   = 2'd2
  } own_e;

  // a transfer boundary: nothing running, or the running transfer ends now
  function automatic logic at_boundary(input logic busy, input logic xend);
    return (!busy) || xend;
  endfunction

  // contention from idle: hardware wins unless software has high priority
  function automatic logic hw_wins_idle(input logic hw, input logic sw_want,
                                        input logic prio_high);
    return hw && ((!sw_want) || (!prio_high));
  endfunction

  // hardware may take the engine from software only at normal priority
  function automatic logic may_preempt(input logic hw, input logic prio_high,
                                       input logic busy, input logic xend);
    return hw && (!prio_high) && at_boundary(busy, xend);
  endfunction

endpackage

// File: rtl/i2c_own_clr.sv
module i2c_own_clr
  import i2c_own_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic status_clr,
  input  logic soft_rst,
  input  own_e owner_q,
  output logic clr_any,
  output logic engine_reset
);

  logic erst_d;

  // both reset flavours wipe the ownership status
  assign clr_any = status_clr | soft_rst;

  // a full engine reset is only safe while software holds the engine
  assign erst_d = soft_rst && (owner_q == OWN_SW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) engine_reset <= 1'b0;
    else        engine_reset <= erst_d;
  end

endmodule

// File: rtl/i2c_own_fsm.sv
module i2c_own_fsm
  import i2c_own_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr_any,
  input  logic sw_req,
  input  logic sw_done,
  input  logic hw_req,
  input  logic prio_high,
  input  logic xact_end,
  input  logic busy_q,
  input  logic pend_q,
  input  logic intr_q,
  output own_e owner_q,
  output logic ev_sw_take,
  output logic ev_hw_take,
  output logic ev_preempt,
  output logic ev_sw_rel,
  output logic ev_hw_rel
);

  own_e owner_d;
  logic sw_want;

  // a held go or an interrupted session counts as a software request
  assign sw_want = sw_req | pend_q | intr_q;

  always_comb begin
    owner_d    = owner_q;
    ev_sw_take = 1'b0;
    ev_hw_take = 1'b0;
    ev_preempt = 1'b0;
    ev_sw_rel  = 1'b0;
    ev_hw_rel  = 1'b0;
    if (clr_any) begin
      owner_d = OWN_IDLE;
    end else begin
      unique case (owner_q)
        OWN_IDLE: begin
          if (hw_wins_idle(hw_req, sw_want, prio_high)) begin
            owner_d    = OWN_HW;
            ev_hw_take = 1'b1;
          end else if (sw_want) begin
            owner_d    = OWN_SW;
            ev_sw_take = 1'b1;
          end
        end
        OWN_SW: begin
          if (sw_done) begin
            owner_d   = OWN_IDLE;
            ev_sw_rel = 1'b1;
          end else if (may_preempt(hw_req, prio_high, busy_q, xact_end)) begin
            owner_d    = OWN_HW;
            ev_preempt = 1'b1;
          end
        end
        OWN_HW: begin
          if (!hw_req) begin
            owner_d   = OWN_IDLE;
            ev_hw_rel = 1'b1;
          end
        end
        default: owner_d = OWN_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) owner_q <= OWN_IDLE;
    else        owner_q <= owner_d;
  end

endmodule

// File: rtl/i2c_own_go.sv
module i2c_own_go
  import i2c_own_pkg::*;
#(
  parameter bit RESTART_EN = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_any,
  input  own_e owner_q,
  input  logic sw_go,
  input  logic sw_done,
  input  logic xact_end,
  input  logic no_queue_go,
  input  logic ev_sw_take,
  input  logic ev_preempt,
  input  logic ev_sw_rel,
  output logic busy_q,
  output logic pend_q,
  output logic intr_q,
  output logic go_fire,
  output logic go_reject,
  output logic restart
);

  logic busy_d, pend_d, intr_d;
  logic fire_d, rej_d, rs_d;
  logic intr_arm;

  // the build chooses whether a preempted software session is resumed
  generate
    if (RESTART_EN) begin : g_resume
      assign intr_arm = 1'b1;
    end else begin : g_noresume
      assign intr_arm = 1'b0;
    end
  endgenerate

  always_comb begin
    busy_d = busy_q;
    pend_d = pend_q;
    intr_d = intr_q;
    fire_d = 1'b0;
    rej_d  = 1'b0;
    rs_d   = 1'b0;
    if (clr_any) begin
      busy_d = 1'b0;
      pend_d = 1'b0;
      intr_d = 1'b0;
    end else if (ev_sw_take) begin
      // a held go starts at once, an interrupted session gets restarted
      fire_d = pend_q;
      rs_d   = intr_q;
      busy_d = pend_q;
      pend_d = 1'b0;
      intr_d = 1'b0;
      rej_d  = sw_go;
    end else begin
      unique case (owner_q)
        OWN_SW: begin
          if (ev_sw_rel) begin
            busy_d = 1'b0;
            rej_d  = sw_go;
          end else if (ev_preempt) begin
            busy_d = 1'b0;
            intr_d = intr_arm;
            if (sw_go) begin
              if (no_queue_go) rej_d  = 1'b1;
              else             pend_d = 1'b1;
            end
          end else if (sw_go && !busy_q) begin
            fire_d = 1'b1;
            busy_d = 1'b1;
          end else begin
            rej_d = sw_go;
            if (xact_end) busy_d = 1'b0;
          end
        end
        OWN_HW: begin
          if (sw_done) begin
            pend_d = 1'b0;
            intr_d = 1'b0;
            rej_d  = sw_go;
          end else if (sw_go) begin
            if (no_queue_go) rej_d  = 1'b1;
            else             pend_d = 1'b1;
          end
        end
        default: rej_d = sw_go;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      pend_q    <= 1'b0;
      intr_q    <= 1'b0;
      go_fire   <= 1'b0;
      go_reject <= 1'b0;
      restart   <= 1'b0;
    end else begin
      busy_q    <= busy_d;
      pend_q    <= pend_d;
      intr_q    <= intr_d;
      go_fire   <= fire_d;
      go_reject <= rej_d;
      restart   <= rs_d;
    end
  end

endmodule

// File: rtl/i2c_own_arb.sv
module i2c_own_arb
  import i2c_own_pkg::*;
#(
  parameter bit RESTART_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_req,
  input  logic             sw_done,
  input  logic             status_clr,
  input  logic             soft_rst,
  input  logic             sw_go,
  input  logic             xact_end,
  input  logic             hw_req,
  input  logic             prio_high,
  input  logic             no_queue_go,
  output logic [OWN_W-1:0] owner,
  output logic             sw_grant,
  output logic             hw_grant,
  output logic             go_fire,
  output logic             go_reject,
  output logic             engine_reset,
  output logic             restart
);

  own_e owner_q;
  logic clr_any;
  logic busy_q, pend_q, intr_q;
  logic ev_sw_take, ev_hw_take, ev_preempt, ev_sw_rel, ev_hw_rel;
  logic take_any;

  i2c_own_clr u_clr (
    .clk          (clk),
    .rst_n        (rst_n),
    .status_clr   (status_clr),
    .soft_rst     (soft_rst),
    .owner_q      (owner_q),
    .clr_any      (clr_any),
    .engine_reset (engine_reset)
  );

  i2c_own_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_any    (clr_any),
    .sw_req     (sw_req),
    .sw_done    (sw_done),
    .hw_req     (hw_req),
    .prio_high  (prio_high),
    .xact_end   (xact_end),
    .busy_q     (busy_q),
    .pend_q     (pend_q),
    .intr_q     (intr_q),
    .owner_q    (owner_q),
    .ev_sw_take (ev_sw_take),
    .ev_hw_take (ev_hw_take),
    .ev_preempt (ev_preempt),
    .ev_sw_rel  (ev_sw_rel),
    .ev_hw_rel  (ev_hw_rel)
  );

  i2c_own_go #(.RESTART_EN(RESTART_EN)) u_go (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_any     (clr_any),
    .owner_q     (owner_q),
    .sw_go       (sw_go),
    .sw_done     (sw_done),
    .xact_end    (xact_end),
    .no_queue_go (no_queue_go),
    .ev_sw_take  (ev_sw_take),
    .ev_preempt  (ev_preempt),
    .ev_sw_rel   (ev_sw_rel),
    .busy_q      (busy_q),
    .pend_q      (pend_q),
    .intr_q      (intr_q),
    .go_fire     (go_fire),
    .go_reject   (go_reject),
    .restart     (restart)
  );

  // ownership changes, brought out as one named event for the checker
  assign take_any = ev_sw_take | ev_hw_take | ev_preempt | ev_sw_rel | ev_hw_rel;

  assign owner    = owner_q;
  assign sw_grant = (owner_q == OWN_SW);
  assign hw_grant = (owner_q == OWN_HW);

endmodule

// File: rtl/i2c_own_arb_chk.sv
module i2c_own_arb_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sw_req,
  input logic       sw_done,
  input logic       status_clr,
  input logic       soft_rst,
  input logic       sw_go,
  input logic       xact_end,
  input logic       hw_req,
  input logic       prio_high,
  input logic       no_queue_go,
  input logic [1:0] owner,
  input logic       sw_grant,
  input logic       hw_grant,
  input logic       go_fire,
  input logic       go_reject,
  input logic       engine_reset,
  input logic       restart,
  input logic       busy,
  input logic       pend,
  input logic       take_any
);

  logic clr;
  assign clr = status_clr | soft_rst;

  AST_OWNER_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    owner != 2'd3);  // R1
  AST_GRANT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(sw_grant && hw_grant));  // R1
  AST_OWNER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!take_any && !clr) |=> $stable(owner));  // R1
  AST_SW_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (owner == 2'd0 && sw_req && !hw_req && !clr) |=> owner == 2'd1);  // R2
  AST_SW_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (owner == 2'd1 && sw_done && !clr) |=> owner == 2'd0);  // R3
  AST_CLR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> owner == 2'd0);  // R4
  AST_ERST_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
    engine_reset |-> ($past(soft_rst) && $past(owner) == 2'd1));  // R5
  AST_FIRE_SW: assert property (@(posedge clk) disable iff (!rst_n)
    go_fire |-> owner == 2'd1);  // R6
  AST_REJ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    go_reject |-> $past(sw_go));  // R6
  AST_NO_MIDXFER_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
    (owner == 2'd1 && busy && !xact_end && !sw_done && !clr) |=> owner != 2'd2);  // R7
  AST_HIGH_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (owner == 2'd1 && prio_high && !sw_done && !clr) |=> owner != 2'd2);  // R8
  AST_TIE_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    (owner == 2'd0 && sw_req && hw_req && !clr) |=> owner == (prio_high ? 2'd1 : 2'd2));  // R9
  AST_NOQUEUE_REJ: assert property (@(posedge clk) disable iff (!rst_n)
    (owner == 2'd2 && sw_go && no_queue_go && !clr) |=> go_reject);  // R10
  AST_HELD_GO: assert property (@(posedge clk) disable iff (!rst_n)
    (owner == 2'd0 && pend && !hw_req && !clr) |=> (go_fire && owner == 2'd1));  // R11
  AST_RESTART_SW: assert property (@(posedge clk) disable iff (!rst_n)
    restart |-> owner == 2'd1);  // R12

endmodule

bind i2c_own_arb i2c_own_arb_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sw_req       (sw_req),
  .sw_done      (sw_done),
  .status_clr   (status_clr),
  .soft_rst     (soft_rst),
  .sw_go        (sw_go),
  .xact_end     (xact_end),
  .hw_req       (hw_req),
  .prio_high    (prio_high),
  .no_queue_go  (no_queue_go),
  .owner        (owner),
  .sw_grant     (sw_grant),
  .hw_grant     (hw_grant),
  .go_fire      (go_fire),
  .go_reject    (go_reject),
  .engine_reset (engine_reset),
  .restart      (restart),
  .busy         (busy_q),
  .pend         (pend_q),
  .take_any     (take_any)
);

// File: tb/sim_i2c_own_arb.sv
module sim_i2c_own_arb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_req = 0, sw_done = 0, status_clr = 0, soft_rst = 0, sw_go = 0;
  logic xact_end = 0, hw_req = 0, prio_high = 0, no_queue_go = 0;
  logic [1:0] owner;
  logic sw_grant, hw_grant, go_fire, go_reject, engine_reset, restart;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  i2c_own_arb u0 (
    .clk(clk), .rst_n(rst_n), .sw_req(sw_req), .sw_done(sw_done),
    .status_clr(status_clr), .soft_rst(soft_rst), .sw_go(sw_go),
    .xact_end(xact_end), .hw_req(hw_req), .prio_high(prio_high),
    .no_queue_go(no_queue_go), .owner(owner), .sw_grant(sw_grant),
    .hw_grant(hw_grant), .go_fire(go_fire), .go_reject(go_reject),
    .engine_reset(engine_reset), .restart(restart)
  );

  // inputs {sw_req,sw_done,status_clr,soft_rst,sw_go,xact_end,hw_req,prio_high,no_queue_go}
  // expected after the edge {owner[1:0], go_fire, go_reject, engine_reset, restart}
  localparam int NV = 29;
  localparam logic [14:0] VEC [NV] = '{
    15'b000000000_00_0000,  // idle stays idle
    15'b100000000_01_0000,  // R2 software takes idle engine
    15'b000010000_01_1000,  // R6 go fires
    15'b000010000_01_0100,  // R6 go while busy rejected
    15'b000000100_01_0000,  // R7 no preemption mid transfer
    15'b000001100_10_0000,  // R7 preempt at transfer end
    15'b000010100_10_0000,  // R10 go held under hardware
    15'b000000000_00_0000,  // hardware releases
    15'b000000000_01_1001,  // R11 R12 held go fires with restart
    15'b000001000_01_0000,  // R6 transfer ends
    15'b010000000_00_0000,  // R3 software release
    15'b100000100_10_0000,  // R9 tie at normal priority
    15'b000010101_10_0100,  // R10 go rejected when queueing off
    15'b000000000_00_0000,  // hardware releases
    15'b100000110_01_0000,  // R9 tie at high priority
    15'b000000110_01_0000,  // R8 hardware waits
    15'b010000110_00_0000,  // R8 release first
    15'b000000110_10_0000,  // R8 hardware then takes
    15'b001000100_00_0000,  // R4 status clear under hardware
    15'b000000100_10_0000,  // hardware takes again
    15'b000100000_00_0000,  // R5 reset request under hardware: status only
    15'b100000000_01_0000,  // R2 software takes
    15'b000100000_00_0010,  // R5 full reset under software
    15'b000010000_00_0100,  // R6 go while idle rejected
    15'b100000000_01_0000,  // R2 software takes
    15'b000000100_10_0000,  // R7 preempt when no transfer
    15'b010000100_10_0000,  // R3 release under hardware cancels restart
    15'b000000000_00_0000,  // hardware releases
    15'b000000000_00_0000   // R3 nothing resumes
  };

  string tags [NV] = '{
    "R1", "R2", "R6", "R6", "R7", "R7", "R10", "R11", "R11", "R6",
    "R3", "R9", "R10", "R11", "R9", "R8", "R8", "R8", "R4", "R4",
    "R5", "R2", "R5", "R6", "R2", "R7", "R3", "R3", "R3"
  };

  task automatic chk(input string req, input string what,
                     input logic [5:0] act, input logic [5:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [8:0] v);
    {sw_req, sw_done, status_clr, soft_rst, sw_go, xact_end, hw_req,
     prio_high, no_queue_go} = v;
  endtask

  task automatic look(input string req, input logic [5:0] exp);
    chk(req, "outputs", {owner, go_fire, go_reject, engine_reset, restart}, exp);
    chk("R1", "grants", {4'b0, sw_grant, hw_grant},
        {4'b0, exp[5:4] == 2'd1, exp[5:4] == 2'd2});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    look("R1", 6'b00_0000);  // reset state
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][14:6]);
      @(negedge clk);
      look(tags[i], VEC[i][5:0]);
    end
    // reset in the middle of software ownership
    drive(9'b100000000);
    @(negedge clk);
    look("R2", 6'b01_0000);
    drive(9'b0);
    rst_n = 1'b0;
    @(negedge clk);
    look("R1", 6'b00_0000);
    rst_n = 1'b1;
    // go in the preempting cycle is held, then fires on resume
    drive(9'b100000000);
    @(negedge clk);
    look("R2", 6'b01_0000);
    drive(9'b000010100);
    @(negedge clk);
    look("R10", 6'b10_0000);
    drive(9'b0);
    @(negedge clk);
    look("R11", 6'b00_0000);
    @(negedge clk);
    look("R12", 6'b01_1001);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule